// File: doc/BRIEF.md
# Clock Source Start/Stop Task Controller

This block sequences five on-chip clock jobs from one-cycle task strobes: three clock sources (a crystal oscillator, a PLL and a low-frequency clock) and two one-shot jobs (an RC calibration and a crystal tuning run). Every clock source has its own four-state sequencer (Stopped, Starting, Started, Stopping). It also has a settle counter that models oscillator start-up and shut-down time in clock cycles. A start task accepted while a stop is still settling turns the source back toward Started. A stop task accepted during start-up aborts it.

Completions raise sticky event flags. An enable mask gates them into a pending mask and one level interrupt line. A small write port holds the enable bits, the event clearing and the low-frequency source select. The select is latched into a shadow when the low-frequency clock is started. It is reported on the status output once that start completes.

Top module: `clk_task_ctrl`

## Requirements
- R1: A start strobe on clock source k (index 0 crystal, 1 PLL, 2 low-frequency) is accepted only in Stopped or Stopping. On acceptance `clkRun[k]` reads 1 after the next edge. A start in Starting or Started is ignored and does not reload the settle time.
- R2: A stop strobe is accepted only in Starting or Started. `clkRun[k]` reads 0 after the next edge and stays 1 otherwise, including after a start has completed.
- R3: Let the accepting edge be E. A start completes at edge E+SETTLE for that source: `clkStat[k]` becomes 1 and event bit k is set. A stop completes at E+SETTLE: `clkStat[k]` becomes 0 and no event is raised.
- R4: A stop accepted in Starting cancels the start, so no started event follows. A start accepted in Stopping reverses the stop, so `clkStat[k]` never drops and the started event is raised SETTLE edges after the start.
- R5: Address 4 writes the low-frequency source select (data bits 1:0). The value present at the accepted low-frequency start appears on `lfStatSrc` when that start completes. Later writes do not change it, and a stop leaves it unchanged.
- R6: The calibration strobe and the tuning strobe are each accepted only while that job is idle. They complete after CAL_SETTLE and TUNE_SETTLE edges and set event bit 3 and event bit 4 respectively. A strobe while busy is ignored.
- R7: Event bit 5 (tuning error) and event bit 6 (tuning failed) are never set.
- R8: `pendMask` equals events AND enable bits, and `irq` is 1 exactly when `pendMask` is nonzero, in the same cycle.
- R9: Enable writes: address 0 loads the 7-bit enable register directly, address 1 sets the bits written as 1, address 2 clears the bits written as 1.
- R10: Events are sticky. A write to address 3 clears every event bit written as 0 and keeps those written as 1. A completion in the same edge as a clearing write leaves its bit set.
- R11: After reset all run, state, event, enable, select and status bits are 0 and `irq` is 0.
- R12: Completions of different sources that fall on the same edge all take effect on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkStartTask | input | 3 | Start strobes, bit 0 crystal, 1 PLL, 2 low-frequency |
| clkStopTask | input | 3 | Stop strobes, same bit order |
| calTask | input | 1 | Calibration job strobe |
| tuneTask | input | 1 | Crystal tuning job strobe |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 3 | Register write address (0..4) |
| regWrData | input | 7 | Register write data |
| clkRun | output | 3 | Run request status per clock source |
| clkStat | output | 3 | Running state per clock source |
| lfStatSrc | output | 2 | Source select reported by the last completed low-frequency start |
| events | output | 7 | Sticky event flags |
| pendMask | output | 7 | Events masked by enable bits |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situations to reach are the reversals and coincidences. These are a start landing inside a stop's settle window, a stop landing inside a start's window, a clearing write on the very edge a job completes, and three sources finishing on one edge. The stimulus reaches them by placing strobes at computed cycle offsets from the accepting edge of each earlier strobe. The expected values are queued for exact cycles, so one cycle of drift in a settle counter shows up as a mismatch.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int NUM_CLK = 3;
  localparam int NUM_EVT = 7;
  localparam int SEL_W   = 2;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] ADR_EN_DIRECT = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_EN_SET    = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_EN_CLR    = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_EVT_WR    = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_LF_SEL    = 3'd4;

  typedef enum logic [1:0] {
    SRC_STOPPED  = 2'd0,
    SRC_STARTING = 2'd1,
    SRC_STARTED  = 2'd2,
    SRC_STOPPING = 2'd3
  } srcState_t;

  typedef struct packed {
    logic [NUM_CLK-1:0] runSet;
    logic [NUM_CLK-1:0] runClr;
    logic [NUM_CLK-1:0] statSet;
    logic [NUM_CLK-1:0] statClr;
    logic               lfLatch;
    logic               calDone;
    logic               tuneDone;
  } ctrlStrobe_t;
endpackage

// File: rtl/clkctl_seq.sv
module clkctl_seq
  import clkctl_pkg::*;
#(
  parameter int SETTLE = 4,
  parameter int CNT_W  = 16,
  parameter bit IS_JOB = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic startTask,
  input  logic stopTask,
  output logic startAcc,
  output logic stopAcc,
  output logic upDone,
  output logic downDone
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SETTLE - 1);

  srcState_t state;
  logic [CNT_W-1:0] cnt;
  logic cntZero, settling;

  assign cntZero  = (cnt == '0);
  assign settling = (state == SRC_STARTING) || (state == SRC_STOPPING);
  assign startAcc = startTask && ((state == SRC_STOPPED) || (state == SRC_STOPPING));
  assign stopAcc  = !IS_JOB && stopTask &&
                    ((state == SRC_STARTED) || (state == SRC_STARTING));
  assign upDone   = (state == SRC_STARTING) && cntZero && !stopAcc;
  assign downDone = (state == SRC_STOPPING) && cntZero && !startAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SRC_STOPPED;
      cnt   <= '0;
    end else if (startAcc) begin
      state <= SRC_STARTING;
      cnt   <= RELOAD;
    end else if (stopAcc) begin
      state <= SRC_STOPPING;
      cnt   <= RELOAD;
    end else if (upDone) begin
      state <= IS_JOB ? SRC_STOPPED : SRC_STARTED;
    end else if (downDone) begin
      state <= SRC_STOPPED;
    end else if (settling) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/clkctl_ctrl.sv
module clkctl_ctrl
  import clkctl_pkg::*;
#(
  parameter int XO_SETTLE   = 6,
  parameter int PLL_SETTLE  = 4,
  parameter int LF_SETTLE   = 10,
  parameter int CAL_SETTLE  = 8,
  parameter int TUNE_SETTLE = 3,
  parameter int CNT_W       = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CLK-1:0] clkStartTask,
  input  logic [NUM_CLK-1:0] clkStopTask,
  input  logic               calTask,
  input  logic               tuneTask,
  output ctrlStrobe_t        strobe
);
  logic [NUM_CLK-1:0] startAcc, stopAcc, upDone, downDone;
  logic calAcc, calStop, calDown, tuneAcc, tuneStop, tuneDown;

  for (genvar i = 0; i < NUM_CLK; i++) begin : gClk
    localparam int S = (i == 0) ? XO_SETTLE : (i == 1) ? PLL_SETTLE : LF_SETTLE;
    clkctl_seq #(.SETTLE(S), .CNT_W(CNT_W), .IS_JOB(1'b0)) uSeq (
      .clk(clk), .rstN(rstN),
      .startTask(clkStartTask[i]), .stopTask(clkStopTask[i]),
      .startAcc(startAcc[i]), .stopAcc(stopAcc[i]),
      .upDone(upDone[i]), .downDone(downDone[i])
    );
  end

  clkctl_seq #(.SETTLE(CAL_SETTLE), .CNT_W(CNT_W), .IS_JOB(1'b1)) uCal (
    .clk(clk), .rstN(rstN), .startTask(calTask), .stopTask(1'b0),
    .startAcc(calAcc), .stopAcc(calStop), .upDone(strobe.calDone), .downDone(calDown)
  );

  clkctl_seq #(.SETTLE(TUNE_SETTLE), .CNT_W(CNT_W), .IS_JOB(1'b1)) uTune (
    .clk(clk), .rstN(rstN), .startTask(tuneTask), .stopTask(1'b0),
    .startAcc(tuneAcc), .stopAcc(tuneStop), .upDone(strobe.tuneDone), .downDone(tuneDown)
  );

  logic jobSideUnused;
  assign jobSideUnused = calAcc ^ calStop ^ calDown ^ tuneAcc ^ tuneStop ^ tuneDown;

  assign strobe.runSet  = startAcc;
  assign strobe.runClr  = stopAcc;
  assign strobe.statSet = upDone;
  assign strobe.statClr = downDone;
  assign strobe.lfLatch = startAcc[NUM_CLK-1] | (jobSideUnused & 1'b0);
endmodule

// File: rtl/clkctl_dp.sv
module clkctl_dp
  import clkctl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_EVT-1:0] regWrData,
  output logic [NUM_CLK-1:0] clkRun,
  output logic [NUM_CLK-1:0] clkStat,
  output logic [SEL_W-1:0]   lfStatSrc,
  output logic [NUM_EVT-1:0] events,
  output logic [NUM_EVT-1:0] pendMask,
  output logic               irq
);
  logic [NUM_EVT-1:0] enable, evtSet, evtKeep, enNext;
  logic [SEL_W-1:0]   lfSel, lfShadow;
  logic               wrEvt, wrSel;

  assign wrEvt   = regWrEn && (regAddr == ADR_EVT_WR);
  assign wrSel   = regWrEn && (regAddr == ADR_LF_SEL);
  assign evtKeep = wrEvt ? regWrData : '1;
  assign evtSet  = {2'b00, strobe.tuneDone, strobe.calDone, strobe.statSet};

  always_comb begin
    enNext = enable;
    if (regWrEn) begin
      case (regAddr)
        ADR_EN_DIRECT: enNext = regWrData;
        ADR_EN_SET:    enNext = enable | regWrData;
        ADR_EN_CLR:    enNext = enable & ~regWrData;
        default:       enNext = enable;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkRun    <= '0;
      clkStat   <= '0;
      lfSel     <= '0;
      lfShadow  <= '0;
      lfStatSrc <= '0;
      events    <= '0;
      enable    <= '0;
    end else begin
      clkRun  <= (clkRun & ~strobe.runClr) | strobe.runSet;
      clkStat <= (clkStat & ~strobe.statClr) | strobe.statSet;
      events  <= (events & evtKeep) | evtSet;
      enable  <= enNext;
      if (wrSel) lfSel <= regWrData[SEL_W-1:0];
      if (strobe.lfLatch) lfShadow <= lfSel;
      if (strobe.statSet[NUM_CLK-1]) lfStatSrc <= lfShadow;
    end
  end

  assign pendMask = events & enable;
  assign irq      = |pendMask;
endmodule

// File: rtl/clk_task_ctrl.sv
module clk_task_ctrl
  import clkctl_pkg::*;
#(
  parameter int XO_SETTLE   = 6,
  parameter int PLL_SETTLE  = 4,
  parameter int LF_SETTLE   = 10,
  parameter int CAL_SETTLE  = 8,
  parameter int TUNE_SETTLE = 3,
  parameter int CNT_W       = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   clkStartTask,
  input  logic [2:0]   clkStopTask,
  input  logic         calTask,
  input  logic         tuneTask,
  input  logic         regWrEn,
  input  logic [2:0]   regAddr,
  input  logic [6:0]   regWrData,
  output logic [2:0]   clkRun,
  output logic [2:0]   clkStat,
  output logic [1:0]   lfStatSrc,
  output logic [6:0]   events,
  output logic [6:0]   pendMask,
  output logic         irq
);
  ctrlStrobe_t strobe;

  clkctl_ctrl #(
    .XO_SETTLE(XO_SETTLE), .PLL_SETTLE(PLL_SETTLE), .LF_SETTLE(LF_SETTLE),
    .CAL_SETTLE(CAL_SETTLE), .TUNE_SETTLE(TUNE_SETTLE), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .clkStartTask(clkStartTask), .clkStopTask(clkStopTask),
    .calTask(calTask), .tuneTask(tuneTask),
    .strobe(strobe)
  );

  clkctl_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .clkRun(clkRun), .clkStat(clkStat), .lfStatSrc(lfStatSrc),
    .events(events), .pendMask(pendMask), .irq(irq)
  );
endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] clkRun,
  input logic [2:0] clkStat,
  input logic [6:0] events,
  input logic [6:0] pendMask,
  input logic       irq
);
  AST_NO_TUNE_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    events[6:5] == 2'b00);                                   // R7
  AST_PEND_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    (pendMask & ~events) == 7'd0);                           // R8
  AST_IRQ_HAS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ($countones(pendMask) != 0));                    // R8

  for (genvar k = 0; k < 3; k++) begin : gSrc
    AST_STAT_UP_RUN: assert property (@(posedge clk) disable iff (!rstN)
      $rose(clkStat[k]) |-> clkRun[k]);                      // R3
    AST_STAT_UP_EVT: assert property (@(posedge clk) disable iff (!rstN)
      $rose(clkStat[k]) |-> events[k]);                      // R3
    AST_STAT_DOWN_NORUN: assert property (@(posedge clk) disable iff (!rstN)
      $fell(clkStat[k]) |-> !clkRun[k]);                     // R2
  end
endmodule

bind clk_task_ctrl clkctl_chk uChk (
  .clk(clk), .rstN(rstN), .clkRun(clkRun), .clkStat(clkStat),
  .events(events), .pendMask(pendMask), .irq(irq)
);

// File: tb/sim_clk_task_ctrl.sv
`timescale 1ns/1ps
module sim_clk_task_ctrl;
  localparam int XO_S = 6, PLL_S = 4, LF_S = 10, CAL_S = 8, TUNE_S = 3;
  localparam int SIG_RUN = 0, SIG_STAT = 1, SIG_EVT = 2, SIG_PEND = 3, SIG_IRQ = 4, SIG_SRC = 5;

  logic clk = 0, rstN = 0;
  logic [2:0] clkStartTask = 0, clkStopTask = 0;
  logic calTask = 0, tuneTask = 0, regWrEn = 0;
  logic [2:0] regAddr = 0;
  logic [6:0] regWrData = 0;
  logic [2:0] clkRun, clkStat;
  logic [1:0] lfStatSrc;
  logic [6:0] events, pendMask;
  logic irq;

  always #2 clk = ~clk;

  clk_task_ctrl #(.XO_SETTLE(XO_S), .PLL_SETTLE(PLL_S), .LF_SETTLE(LF_S),
                  .CAL_SETTLE(CAL_S), .TUNE_SETTLE(TUNE_S)) u0 (.*);

  typedef struct { int at; int sig; int val; string req; } item_t;
  item_t q[$];
  int cyc = 0, nChecks = 0, nFails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int actual(int sig);
    case (sig)
      SIG_RUN:  return int'(clkRun);
      SIG_STAT: return int'(clkStat);
      SIG_EVT:  return int'(events);
      SIG_PEND: return int'(pendMask);
      SIG_IRQ:  return int'(irq);
      default:  return int'(lfStatSrc);
    endcase
  endfunction

  // monitor: pops items due in this cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        nChecks++;
        if (actual(q[i].sig) != q[i].val) begin
          nFails++;
          $display("FAIL %s cyc=%0d sig=%0d actual=%0h expected=%0h",
                   q[i].req, cyc, q[i].sig, actual(q[i].sig), q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic expectAt(int at, int sig, int val, string req);
    item_t it;
    it.at = at; it.sig = sig; it.val = val; it.req = req;
    q.push_back(it);
  endtask

  // codes: 0..2 start, 3..5 stop, 6 cal, 7 tune
  task automatic strobe(int code);
    if (code < 3) clkStartTask[code] = 1'b1;
    else if (code < 6) clkStopTask[code-3] = 1'b1;
    else if (code == 6) calTask = 1'b1;
    else tuneTask = 1'b1;
    @(posedge clk); #1;
    clkStartTask = 0; clkStopTask = 0; calTask = 0; tuneTask = 0;
  endtask

  task automatic regWrite(logic [2:0] a, logic [6:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int t;
    repeat (3) @(posedge clk); #1;
    rstN = 1;
    // R11 reset state
    t = cyc;
    expectAt(t, SIG_RUN, 0, "R11"); expectAt(t, SIG_STAT, 0, "R11");
    expectAt(t, SIG_EVT, 0, "R11"); expectAt(t, SIG_PEND, 0, "R11");
    expectAt(t, SIG_IRQ, 0, "R11"); expectAt(t, SIG_SRC, 0, "R11");
    idle(1);

    // R1 R3: crystal start, repeated start ignored
    t = cyc;
    expectAt(t+1, SIG_RUN, 1, "R1");
    expectAt(t+1+XO_S-1, SIG_STAT, 0, "R1 no reload");
    expectAt(t+1+XO_S-1, SIG_EVT, 0, "R3");
    expectAt(t+1+XO_S, SIG_STAT, 1, "R3");
    expectAt(t+1+XO_S, SIG_EVT, 1, "R3");
    strobe(0); strobe(0);
    idle(8);

    // R2 R3: stop, no event
    t = cyc; regWrite(3'd3, 7'd0);
    expectAt(t+1, SIG_EVT, 0, "R10 clear");
    t = cyc;
    expectAt(t+1, SIG_RUN, 0, "R2");
    expectAt(t+XO_S, SIG_STAT, 1, "R3 stop settling");
    expectAt(t+1+XO_S, SIG_STAT, 0, "R3 stop done");
    expectAt(t+2+XO_S, SIG_EVT, 0, "R3 stop no event");
    strobe(3);
    idle(9);

    // R4: stop during Starting cancels start
    t = cyc;
    expectAt(t+1, SIG_RUN, 3'b010, "R1 pll");
    expectAt(t+2, SIG_RUN, 0, "R4 cancel");
    expectAt(t+6, SIG_STAT, 0, "R4 cancel");
    expectAt(t+7, SIG_EVT, 0, "R4 no started event");
    strobe(1); strobe(4);
    idle(8);

    // R4: start during Stopping reverses
    t = cyc;
    expectAt(t+1+PLL_S, SIG_EVT, 7'h02, "R3 pll");
    strobe(1); idle(6);
    regWrite(3'd3, 7'd0);
    t = cyc;
    expectAt(t+1, SIG_RUN, 0, "R2 pll");
    expectAt(t+2, SIG_RUN, 3'b010, "R4 restart");
    expectAt(t+5, SIG_STAT, 3'b010, "R4 stat held");
    expectAt(t+5, SIG_EVT, 0, "R4");
    expectAt(t+6, SIG_EVT, 7'h02, "R4 started event");
    strobe(4); strobe(1);
    idle(7);

    // R5: source select latched at start
    regWrite(3'd4, 7'd2);
    t = cyc;
    expectAt(t+LF_S, SIG_SRC, 0, "R5 before");
    expectAt(t+1+LF_S, SIG_SRC, 2, "R5 latched");
    expectAt(t+1+LF_S, SIG_STAT, 3'b110, "R3 lf");
    expectAt(t+1+LF_S, SIG_EVT, 7'h06, "R3 lf event");
    strobe(2); regWrite(3'd4, 7'd1);
    idle(12);
    t = cyc;
    expectAt(t+1+LF_S, SIG_STAT, 3'b010, "R3 lf stop");
    expectAt(t+1+LF_S, SIG_SRC, 2, "R5 kept on stop");
    strobe(5);
    idle(12);

    // R6 R7: calibration with busy retrigger
    regWrite(3'd3, 7'd0);
    t = cyc;
    expectAt(t+CAL_S, SIG_EVT, 0, "R6 busy ignored");
    expectAt(t+1+CAL_S, SIG_EVT, 7'h08, "R6 cal done");
    strobe(6); strobe(6);
    idle(10);
    t = cyc;
    expectAt(t+TUNE_S, SIG_EVT, 7'h08, "R6 tune");
    expectAt(t+1+TUNE_S, SIG_EVT, 7'h18, "R6 tuned");
    expectAt(t+3+TUNE_S, SIG_EVT, 7'h18, "R7 no fault bits");
    strobe(7);
    idle(6);

    // R8 R9 R10: enable register and event write
    t = cyc;
    expectAt(t+1, SIG_PEND, 7'h08, "R9 direct");
    expectAt(t+1, SIG_IRQ, 1, "R8");
    expectAt(t+2, SIG_PEND, 7'h08, "R9 set");
    expectAt(t+3, SIG_PEND, 0, "R9 clear");
    expectAt(t+3, SIG_IRQ, 0, "R8");
    expectAt(t+4, SIG_PEND, 7'h10, "R9 set");
    expectAt(t+4, SIG_IRQ, 1, "R8");
    expectAt(t+5, SIG_EVT, 7'h08, "R10 selective clear");
    expectAt(t+5, SIG_IRQ, 0, "R8");
    regWrite(3'd0, 7'h08); regWrite(3'd1, 7'h02);
    regWrite(3'd2, 7'h08); regWrite(3'd1, 7'h10);
    regWrite(3'd3, 7'h6F);

    // R10: set beats clear on the same edge
    t = cyc;
    expectAt(t+4, SIG_EVT, 7'h10, "R10 set wins");
    expectAt(t+4, SIG_IRQ, 1, "R8");
    strobe(7); idle(2); regWrite(3'd3, 7'd0);
    idle(2);

    // R12: three completions on one edge
    regWrite(3'd3, 7'd0);
    t = cyc;
    expectAt(t+10, SIG_EVT, 0, "R12 before");
    expectAt(t+11, SIG_EVT, 7'h15, "R12 together");
    expectAt(t+11, SIG_STAT, 3'b111, "R12 stat");
    expectAt(t+11, SIG_SRC, 1, "R5 new select");
    strobe(2); idle(3); strobe(0); idle(2); strobe(7);
    idle(12);

    while (q.size() != 0) idle(1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule